// File: doc/BRIEF.md
# Atomic-Update GPIO Register Bank

This block is a memory-mapped controller for one bank of general-purpose pins, up to 32 wide. It sits on a simple word-wide register bus made of a byte address, write data, a write strobe, a read strobe and read data. Two control registers live inside it. The direction register decides which pins are driven. The level register holds the value a driven pin shows. A read-only view returns the pin inputs after they pass a synchroniser.

Each control register has four addresses, and each address changes the register in its own way. The first replaces the whole register. The second forces the bits that are 1 in the write data to 1. The third forces them to 0. The fourth inverts them. Firmware can therefore change one pin in a single bus write and needs no read-modify-write sequence, which another agent could interrupt. Any of the four addresses reads back the register's current value.

The block has no sequencing state. Its only states are the two registers, the synchroniser chain and the read-data register. Reads are registered, so data appears one cycle after the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction and level registers are zero, `pin_oe` and `pin_out` are zero, and `bus_rdata` is zero.
- R2: A write to byte offset 0x00 replaces the direction register with `bus_wdata`, and a write to 0x10 replaces the level register. The new value is visible after the clock edge that samples `bus_we`.
- R3: A write to 0x04 (direction) or 0x14 (level) sets every bit that is 1 in `bus_wdata` and leaves the other bits unchanged.
- R4: A write to 0x08 (direction) or 0x18 (level) clears every bit that is 1 in `bus_wdata` and leaves the other bits unchanged.
- R5: A write to 0x0C (direction) or 0x1C (level) inverts every bit that is 1 in `bus_wdata` and leaves the other bits unchanged.
- R6: A read of any of the four offsets of a register (0x00–0x0C for direction, 0x10–0x1C for level) returns that register's value on `bus_rdata` after the edge that samples `bus_re`. `bus_rdata` holds that value until the next read.
- R7: A read of offset 0x20 returns the pin inputs after a two-flop synchroniser. A level that `pin_in` takes before a rising edge is returned by a read sampled on the third rising edge after that change or later. Reads sampled on the first two edges return the earlier level.
- R8: `pin_oe` equals the direction register. Each `pin_out` bit equals the level bit where the direction bit is 1 and is 0 where the direction bit is 0 (tri-stated).
- R9: Reads at unmapped offsets (above 0x20, or with address bits [1:0] not 00) return zero. Writes to them change neither register.
- R10: Writes to the input offset 0x20 change neither register.
- R11: When `bus_re` and `bus_we` are both high in one cycle, the read returns the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pin_in | input | NUM_PINS (32) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (32) | Level driven onto each pin, 0 when not driven |
| pin_oe | output | NUM_PINS (32) | Drive enable for each pin |

## Verification
If a control register holds a wrong value, `pin_oe` or `pin_out` shows it on the first cycle after the faulty write. A read at any alias shows it one cycle after the strobe. A fault in the synchroniser shows up as a read at 0x20 that returns a pin change one edge too early or too late. A decode fault shows up either as nonzero data from an unmapped offset or as a register that changes on a write that should have had no effect. The bench keeps its own model of both registers and of the pin history and compares every output on every clock. Directed checks cover each alias, the bank edges and the synchroniser delay.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Low two bits of the register word index select the update kind.
    typedef enum logic [1:0] {
        ALT_WRITE  = 2'd0,
        ALT_SET    = 2'd1,
        ALT_CLEAR  = 2'd2,
        ALT_TOGGLE = 2'd3
    } alt_op_e;

    // Which storage an access reaches.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_DIR   = 2'd1,
        TGT_LEVEL = 2'd2,
        TGT_PINS  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e    tgt;
        alt_op_e op;
    } access_t;

endpackage

// File: rtl/gbk_addr_decode.sv
module gbk_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] PIN_IDX = IDX_W'(8);

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // Word index 0..3 -> direction, 4..7 -> level, 8 -> pin inputs.
    always_comb begin
        acc.tgt = TGT_NONE;
        acc.op  = ALT_WRITE;
        if (addr[1:0] == 2'b00) begin
            if (idx < PIN_IDX) begin
                acc.tgt = idx[2] ? TGT_LEVEL : TGT_DIR;
                acc.op  = alt_op_e'(idx[1:0]);
            end else if (idx == PIN_IDX) begin
                acc.tgt = TGT_PINS;
            end
        end
    end

endmodule

// File: rtl/gbk_ctl_reg.sv
module gbk_ctl_reg
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  alt_op_e      op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            unique case (op)
                ALT_WRITE:  q <= wdata;
                ALT_SET:    q <= q | wdata;
                ALT_CLEAR:  q <= q & ~wdata;
                ALT_TOGGLE: q <= q ^ wdata;
            endcase
        end
    end

endmodule

// File: rtl/gbk_in_sync.sv
module gbk_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    access_t             acc;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] lvl_q;
    logic [NUM_PINS-1:0] pins_sync;
    logic [DATA_W-1:0]   rd_word;
    logic                wr_dir;
    logic                wr_lvl;

    gbk_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    assign wr_dir = bus_we && (acc.tgt == TGT_DIR);
    assign wr_lvl = bus_we && (acc.tgt == TGT_LEVEL);

    gbk_ctl_reg #(.W(NUM_PINS)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_dir),
        .op    (acc.op),
        .wdata (bus_wdata[NUM_PINS-1:0]),
        .q     (dir_q)
    );

    gbk_ctl_reg #(.W(NUM_PINS)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_lvl),
        .op    (acc.op),
        .wdata (bus_wdata[NUM_PINS-1:0]),
        .q     (lvl_q)
    );

    gbk_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    always_comb begin
        rd_word = '0;
        unique case (acc.tgt)
            TGT_DIR:   rd_word[NUM_PINS-1:0] = dir_q;
            TGT_LEVEL: rd_word[NUM_PINS-1:0] = lvl_q;
            TGT_PINS:  rd_word[NUM_PINS-1:0] = pins_sync;
            TGT_NONE:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_word;
    end

    assign pin_oe  = dir_q;
    assign pin_out = lvl_q & dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_we,
    input logic                bus_re,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] lvl_q
);
    logic                unmapped;
    logic [NUM_PINS-1:0] wd;
    assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:2] > (ADDR_W-2)'(8));
    assign wd       = bus_wdata[NUM_PINS-1:0];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0) && (bus_rdata == '0));

    // R2
    lvl_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h10)) |=> (lvl_q == $past(wd)));

    // R3
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h04)) |=>
        ((dir_q & $past(wd)) == $past(wd)) && ((dir_q & ~$past(wd)) == ($past(dir_q) & ~$past(wd))));

    // R4
    lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h18)) |=>
        ((lvl_q & $past(wd)) == '0) && ((lvl_q & ~$past(wd)) == ($past(lvl_q) & ~$past(wd))));

    // R5
    dir_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h0C)) |=> (dir_q == ($past(dir_q) ^ $past(wd))));

    // R6
    alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(8'h08)) |=> (bus_rdata[NUM_PINS-1:0] == $past(dir_q)));

    // R8
    tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && unmapped) |=> (bus_rdata == '0));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && unmapped) |=> $stable(dir_q) && $stable(lvl_q));

endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .lvl_q     (lvl_q)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Behavioural reference model
    logic [31:0] m_dir, m_lvl, m_rd;
    logic [31:0] hist[$];

    function automatic logic [31:0] m_pins();
        if (hist.size() >= 2) return hist[hist.size()-2];
        return 32'h0;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h20) return m_pins();
        if (a[1:0] != 2'b00 || a > 8'h1C) return 32'h0;
        return (a < 8'h10) ? m_dir : m_lvl;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = '0; m_lvl = '0; m_rd = '0;
            hist.delete();
        end else begin
            if (bus_re) m_rd = m_read(bus_addr);
            if (bus_we && bus_addr[1:0] == 2'b00 && bus_addr <= 8'h1C) begin
                logic [31:0] cur;
                cur = (bus_addr < 8'h10) ? m_dir : m_lvl;
                case (bus_addr[3:2])
                    2'd0: cur = bus_wdata;
                    2'd1: cur = cur | bus_wdata;
                    2'd2: cur = cur & ~bus_wdata;
                    default: cur = cur ^ bus_wdata;
                endcase
                if (bus_addr < 8'h10) m_dir = cur; else m_lvl = cur;
            end
            hist.push_back(pin_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_rdata === m_rd, "R6/R7/R9 rdata vs model", bus_rdata, m_rd);
            chk(pin_oe === m_dir, "R8 pin_oe vs model", pin_oe, m_dir);
            chk(pin_out === (m_lvl & m_dir), "R8 pin_out vs model", pin_out, m_lvl & m_dir);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        logic [31:0] d;
        rd(a, d);
        chk(d === e, tag, d, e);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_oe === 32'h0, "R1 pin_oe after reset", pin_oe, 32'h0);
        chk(pin_out === 32'h0, "R1 pin_out after reset", pin_out, 32'h0);
        chk(bus_rdata === 32'h0, "R1 rdata after reset", bus_rdata, 32'h0);
        rd_exp(8'h00, 32'h0, "R1 direction reset");
        rd_exp(8'h10, 32'h0, "R1 level reset");

        wr(8'h00, 32'h0000FFFF);
        rd_exp(8'h00, 32'h0000FFFF, "R2 direction write");
        rd_exp(8'h04, 32'h0000FFFF, "R6 alias set read");
        rd_exp(8'h08, 32'h0000FFFF, "R6 alias clear read");
        rd_exp(8'h0C, 32'h0000FFFF, "R6 alias toggle read");
        wr(8'h10, 32'hA5A5A5A5);
        rd_exp(8'h1C, 32'hA5A5A5A5, "R2 level write via toggle alias R6");
        chk(pin_out === 32'h0000A5A5, "R8 gated output", pin_out, 32'h0000A5A5);

        wr(8'h04, 32'h00FF0000);
        rd_exp(8'h00, 32'h00FFFFFF, "R3 direction set");
        wr(8'h14, 32'h0000000F);
        rd_exp(8'h10, 32'hA5A5A5AF, "R3 level set");
        wr(8'h08, 32'h0000000F);
        rd_exp(8'h00, 32'h00FFFFF0, "R4 direction clear");
        wr(8'h18, 32'hA0000000);
        rd_exp(8'h14, 32'h05A5A5AF, "R4 level clear");
        wr(8'h0C, 32'hFF0000FF);
        rd_exp(8'h00, 32'hFFFFFF0F, "R5 direction toggle");
        wr(8'h1C, 32'h0000FFFF);
        rd_exp(8'h10, 32'h05A55A50, "R5 level toggle");
        chk(pin_oe === 32'hFFFFFF0F, "R8 pin_oe", pin_oe, 32'hFFFFFF0F);
        chk(pin_out === 32'h05A55A00, "R8 pin_out masked", pin_out, 32'h05A55A00);

        // Hold of read data while registers change
        wr(8'h14, 32'hFFFFFFFF);
        chk(bus_rdata === 32'h05A55A50, "R6 rdata holds", bus_rdata, 32'h05A55A50);

        // Unmapped and read-only offsets
        wr(8'h24, 32'hFFFFFFFF);
        wr(8'h02, 32'h00000000);
        wr(8'hFC, 32'h00000000);
        rd_exp(8'h00, 32'hFFFFFF0F, "R9 direction untouched");
        rd_exp(8'h10, 32'hFFFFFFFF, "R9 level untouched");
        wr(8'h20, 32'h00000000);
        rd_exp(8'h00, 32'hFFFFFF0F, "R10 direction untouched");
        rd_exp(8'h10, 32'hFFFFFFFF, "R10 level untouched");
        rd_exp(8'h24, 32'h0, "R9 read above bank");
        rd_exp(8'hFC, 32'h0, "R9 read top");
        rd_exp(8'h11, 32'h0, "R9 read misaligned");

        // Synchroniser delay: reads on three consecutive edges
        pin_in = 32'h0;
        repeat (4) @(negedge clk);
        pin_in = 32'h12345678;
        bus_addr = 8'h20; bus_re = 1'b1;
        @(negedge clk);
        chk(bus_rdata === 32'h0, "R7 first edge old level", bus_rdata, 32'h0);
        @(negedge clk);
        chk(bus_rdata === 32'h0, "R7 second edge old level", bus_rdata, 32'h0);
        @(negedge clk);
        chk(bus_rdata === 32'h12345678, "R7 third edge new level", bus_rdata, 32'h12345678);
        bus_re = 1'b0;
        pin_in = 32'hCAFE0001;
        repeat (3) @(negedge clk);
        rd_exp(8'h20, 32'hCAFE0001, "R7 settled level");

        // Simultaneous read and write
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h00000011; bus_we = 1'b1; bus_re = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        chk(bus_rdata === 32'hFFFFFF0F, "R11 read sees old value", bus_rdata, 32'hFFFFFF0F);
        rd(8'h00, d);
        chk(d === 32'h00000011, "R11 write still applied", d, 32'h00000011);

        // Reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_oe === 32'h0, "R1 pin_oe after second reset", pin_oe, 32'h0);
        rd_exp(8'h10, 32'h0, "R1 level after second reset");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule